// File: doc/BRIEF.md
# Byte-Coded Accumulator Processor Core

This block is a small 8-bit processor core. Code and data share one flat 256-byte space reached through a single synchronous memory port. The port presents an address in one cycle and receives the read byte in the next. There is no banking and there are no I/O ports. Peripherals are reached by placing them in the shared memory. The core holds four architectural registers: the instruction register, an accumulator, the program counter and a status register.

Each instruction is one byte. The high nibble selects the operation. Bits 3:2 choose the target and bits 1:0 choose the source. Any selector may name the program counter or the status register, so a jump is simply a move into the program counter. Selector code 0 names the byte that follows the instruction in memory. It is the only way an instruction can read an inline constant, and the only way it can write memory. The arithmetic and flag logic sits in its own ALU, and branch condition testing sits in a separate unit.

Top module: `nib_core`

## Requirements
- R1: Reset clears the program counter, the accumulator and the status register. The first instruction fetch after reset reads address 0x00.
- R2: An instruction byte holds the opcode in bits 7:4, the target selector in bits 3:2 and the source selector in bits 1:0. Opcodes 0x0 to 0xF are, in order: add, subtract, multiply, divide, remainder, increment, decrement, move, and, or, xor, compare, branch-on-zero, branch-on-less, branch-on-equal, branch-on-greater. Selector 0 means the memory byte following the instruction, 1 the accumulator, 2 the program counter and 3 the status register.
- R3: An instruction takes 3 clock cycles: fetch, decode, execute. It takes 4 when it consumes the following byte, which happens when either selector is 0 or the opcode is a branch. The fetch cycle drives the program counter on the address port. The decode cycle and any operand cycle drive the program counter plus one.
- R4: When no branch is taken and the program counter is not written, it advances by 2 if the following byte was consumed and by 1 otherwise. The result wraps modulo 256, and the program counter changes only at the end of the execute cycle.
- R5: Memory is written only by an instruction whose target selector is 0 and whose opcode writes a result. The write happens in its execute cycle, at the address of the instruction plus one. No other instruction asserts the write enable.
- R6: A result written to the program counter becomes the next fetch address; the byte pair 0x78, addr jumps to addr.
- R7: Move (opcode 0x7) copies the source value to the target and leaves the status register unchanged.
- R8: Add, subtract, multiply, increment and decrement produce the low 8 bits of the result. Carry (status bit 4) is set by an add carry-out, a product above 255 or an increment of 0xFF. Negative (status bit 5) is set by a subtract borrow or a decrement of 0x00.
- R9: Divide and remainder produce the quotient and remainder. With a zero divisor the target keeps its value and the status becomes zero|equal (0x05).
- R10: Opcodes 0x0 to 0x6 and 0x8 to 0xB replace the whole status register. Zero (bit 0) marks a zero result. Less, equal and greater (bits 1, 2, 3) compare the new target value with the old one. For compare, which writes no result and clears zero, carry and negative, they compare the target with the source. Bits 7:6 read 0.
- R11: When the target selector is 3, the operation's result is written to the status register in place of the computed flags.
- R12: Branch opcodes 0xC to 0xF test status bit 0 to 3 respectively. If that bit is set, the following byte becomes the next fetch address. Otherwise execution continues two bytes on. The selector fields of a branch are ignored.
- R13: The program counter read as a source gives the address of the executing instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address for read or write |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable, sampled by memory on the rising edge |
| mem_rdata | input | 8 | Read data for the address presented one cycle earlier |

## Verification
Some behaviour is only visible through memory writes: the status bits after a divide by zero, a status write that must override the flags, and self-modifying stores that land on bytes about to be fetched. A bench model replays each program at the instruction level. Every write on the port is compared in order, with the total cycle count fixed by the model. Random 256-byte images exercise the tangled cases, because any byte is a legal instruction. Directed images reach the corners that random code seldom hits: a wrap from address 0xFF, a divisor of zero, and a branch not taken followed by one taken.

// File: rtl/nib_pkg.sv
package nib_pkg;

    localparam int DW   = 8;
    localparam int AW   = DW;
    localparam int OPW  = 4;
    localparam int SELW = 2;
    localparam int NSEL = 2;

    // status bit positions (software-visible)
    localparam int FLAG_ZERO = 0;
    localparam int FLAG_LESS = 1;
    localparam int FLAG_EQU  = 2;
    localparam int FLAG_GRT  = 3;
    localparam int FLAG_CRY  = 4;
    localparam int FLAG_NEG  = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'h0, OP_SUB = 4'h1, OP_MUL = 4'h2, OP_DIV = 4'h3,
        OP_REM = 4'h4, OP_INC = 4'h5, OP_DEC = 4'h6, OP_MOV = 4'h7,
        OP_AND = 4'h8, OP_IOR = 4'h9, OP_XOR = 4'hA, OP_CMP = 4'hB,
        OP_BZE = 4'hC, OP_BLT = 4'hD, OP_BEQ = 4'hE, OP_BGT = 4'hF
    } opcode_e;

    typedef enum logic [SELW-1:0] {
        SEL_MEM = 2'd0,
        SEL_ACC = 2'd1,
        SEL_PC  = 2'd2,
        SEL_STS = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_OPER   = 2'd2,
        PH_EXEC   = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] pc;
        logic [DW-1:0] acc;
        logic [DW-1:0] sts;
        logic [DW-1:0] ir;
        logic [DW-1:0] opnd;
    } core_regs_t;

    function automatic logic is_branch_op(input logic [DW-1:0] instr);
        return instr[DW-1 -: 2] == 2'b11;
    endfunction

    function automatic logic needs_operand(input logic [DW-1:0] instr);
        return is_branch_op(instr)
            || (instr[3:2] == SEL_MEM)
            || (instr[1:0] == SEL_MEM);
    endfunction

endpackage

// File: rtl/nib_opsel.sv
module nib_opsel
    import nib_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [SELW-1:0] sel,
    input  logic [W-1:0]    mem_val,
    input  logic [W-1:0]    acc_val,
    input  logic [W-1:0]    pc_val,
    input  logic [W-1:0]    sts_val,
    output logic [W-1:0]    val
);

    always_comb begin
        unique case (sel_e'(sel))
            SEL_MEM: val = mem_val;
            SEL_ACC: val = acc_val;
            SEL_PC:  val = pc_val;
            SEL_STS: val = sts_val;
            default: val = '0;
        endcase
    end

endmodule

// File: rtl/nib_branch.sv
module nib_branch
    import nib_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [OPW-1:0] opcode,
    input  logic [W-1:0]   sts,
    output logic           is_branch,
    output logic           taken
);

    logic cond_bit;

    always_comb begin
        is_branch = opcode[OPW-1 -: 2] == 2'b11;
        unique case (opcode_e'(opcode))
            OP_BZE:  cond_bit = sts[FLAG_ZERO];
            OP_BLT:  cond_bit = sts[FLAG_LESS];
            OP_BEQ:  cond_bit = sts[FLAG_EQU];
            OP_BGT:  cond_bit = sts[FLAG_GRT];
            default: cond_bit = 1'b0;
        endcase
        taken = is_branch && cond_bit;
    end

endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [OPW-1:0] opcode,
    input  logic [W-1:0]   tgt_val,
    input  logic [W-1:0]   src_val,
    output logic [W-1:0]   result,
    output logic [W-1:0]   flags,
    output logic           wr_result,
    output logic           wr_flags
);

    localparam int PW = 2 * W;

    logic [W:0]    sum_w;
    logic [PW-1:0] prod_w;
    logic          carry;
    logic          negative;
    logic          div_zero;
    logic          cmp_mode;
    logic [W-1:0]  lhs;
    logic [W-1:0]  rhs;
    opcode_e       op;

    assign op     = opcode_e'(opcode);
    assign sum_w  = {1'b0, tgt_val} + {1'b0, src_val};
    assign prod_w = {{W{1'b0}}, tgt_val} * {{W{1'b0}}, src_val};

    always_comb begin
        result   = tgt_val;
        carry    = 1'b0;
        negative = 1'b0;
        div_zero = 1'b0;
        cmp_mode = 1'b0;
        unique case (op)
            OP_ADD: begin
                result = sum_w[W-1:0];
                carry  = sum_w[W];
            end
            OP_SUB: begin
                result   = tgt_val - src_val;
                negative = src_val > tgt_val;
            end
            OP_MUL: begin
                result = prod_w[W-1:0];
                carry  = |prod_w[PW-1:W];
            end
            OP_DIV: begin
                if (src_val == '0) div_zero = 1'b1;
                else               result   = tgt_val / src_val;
            end
            OP_REM: begin
                if (src_val == '0) div_zero = 1'b1;
                else               result   = tgt_val % src_val;
            end
            OP_INC: begin
                result = tgt_val + W'(1);
                carry  = &tgt_val;
            end
            OP_DEC: begin
                result   = tgt_val - W'(1);
                negative = ~|tgt_val;
            end
            OP_MOV: result = src_val;
            OP_AND: result = tgt_val & src_val;
            OP_IOR: result = tgt_val | src_val;
            OP_XOR: result = tgt_val ^ src_val;
            OP_CMP: cmp_mode = 1'b1;
            default: result = tgt_val;
        endcase
    end

    // relation operands: compare checks target vs source, others new vs old
    assign lhs = cmp_mode ? tgt_val : result;
    assign rhs = cmp_mode ? src_val : tgt_val;

    always_comb begin
        flags            = '0;
        flags[FLAG_ZERO] = !cmp_mode && ((result == '0) || div_zero);
        flags[FLAG_LESS] = lhs <  rhs;
        flags[FLAG_EQU]  = lhs == rhs;
        flags[FLAG_GRT]  = lhs >  rhs;
        flags[FLAG_CRY]  = carry;
        flags[FLAG_NEG]  = negative;
    end

    assign wr_result = opcode <= OP_XOR;
    assign wr_flags  = (opcode <= OP_CMP) && (op != OP_MOV);

endmodule

// File: rtl/nib_core.sv
module nib_core
    import nib_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata
);

    localparam core_regs_t REGS_RESET = '{
        phase: PH_FETCH,
        pc:    RESET_PC,
        acc:   '0,
        sts:   '0,
        ir:    '0,
        opnd:  '0
    };

    core_regs_t cur_q;
    core_regs_t nxt_d;

    // decoded fields of the held instruction
    logic [OPW-1:0]  op_field;
    logic [SELW-1:0] sel_field [NSEL];
    logic [DW-1:0]   sel_val   [NSEL];
    logic            uses_opnd;
    logic [AW-1:0]   pc_plus1;
    logic [AW-1:0]   pc_plus2;

    assign op_field     = cur_q.ir[DW-1 -: OPW];
    assign sel_field[0] = cur_q.ir[3:2];   // target
    assign sel_field[1] = cur_q.ir[1:0];   // source
    assign uses_opnd    = needs_operand(cur_q.ir);
    assign pc_plus1     = cur_q.pc + AW'(1);
    assign pc_plus2     = cur_q.pc + AW'(2);

    genvar gi;
    generate
        for (gi = 0; gi < NSEL; gi++) begin : g_sel
            nib_opsel #(.W(DW)) u_opsel (
                .sel     (sel_field[gi]),
                .mem_val (cur_q.opnd),
                .acc_val (cur_q.acc),
                .pc_val  (cur_q.pc),
                .sts_val (cur_q.sts),
                .val     (sel_val[gi])
            );
        end
    endgenerate

    logic [DW-1:0] alu_res;
    logic [DW-1:0] alu_flags;
    logic          alu_wr_res;
    logic          alu_wr_flags;

    nib_alu #(.W(DW)) u_alu (
        .opcode    (op_field),
        .tgt_val   (sel_val[0]),
        .src_val   (sel_val[1]),
        .result    (alu_res),
        .flags     (alu_flags),
        .wr_result (alu_wr_res),
        .wr_flags  (alu_wr_flags)
    );

    logic br_is;
    logic br_taken;

    nib_branch #(.W(DW)) u_branch (
        .opcode    (op_field),
        .sts       (cur_q.sts),
        .is_branch (br_is),
        .taken     (br_taken)
    );

    always_comb begin
        nxt_d     = cur_q;
        mem_addr  = pc_plus1;
        mem_wdata = alu_res;
        mem_we    = 1'b0;
        unique case (cur_q.phase)
            PH_FETCH: begin
                mem_addr    = cur_q.pc;
                nxt_d.phase = PH_DECODE;
            end
            PH_DECODE: begin
                nxt_d.ir    = mem_rdata;
                nxt_d.phase = needs_operand(mem_rdata) ? PH_OPER : PH_EXEC;
            end
            PH_OPER: begin
                nxt_d.opnd  = mem_rdata;
                nxt_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                nxt_d.phase = PH_FETCH;
                if (br_is) begin
                    nxt_d.pc = br_taken ? cur_q.opnd : pc_plus2;
                end else begin
                    nxt_d.pc = uses_opnd ? pc_plus2 : pc_plus1;
                    if (alu_wr_flags) nxt_d.sts = alu_flags;
                    if (alu_wr_res) begin
                        unique case (sel_e'(sel_field[0]))
                            SEL_MEM: mem_we    = 1'b1;
                            SEL_ACC: nxt_d.acc = alu_res;
                            SEL_PC:  nxt_d.pc  = alu_res;
                            SEL_STS: nxt_d.sts = alu_res;
                            default: nxt_d.acc = cur_q.acc;
                        endcase
                    end
                end
            end
            default: nxt_d.phase = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= REGS_RESET;
        else     cur_q <= nxt_d;
    end

endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk
    import nib_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input core_regs_t    regs
);

    assert_we_phase_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (regs.phase == PH_EXEC) && (regs.ir[3:2] == SEL_MEM));

    assert_we_addr_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr == AW'(regs.pc + AW'(1)));

    assert_fetch_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (regs.phase == PH_FETCH) |-> mem_addr == regs.pc);

    assert_fetch_seq_R3: assert property (@(posedge clk) disable iff (rst)
        (regs.phase == PH_FETCH) |=> (regs.phase == PH_DECODE));

    assert_oper_seq_R3: assert property (@(posedge clk) disable iff (rst)
        (regs.phase == PH_OPER) |=> (regs.phase == PH_EXEC));

    assert_exec_seq_R3: assert property (@(posedge clk) disable iff (rst)
        (regs.phase == PH_EXEC) |=> (regs.phase == PH_FETCH));

    assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (regs.phase != PH_EXEC) |=> $stable(regs.pc));

    assert_mov_keeps_sts_R7: assert property (@(posedge clk) disable iff (rst)
        (regs.phase == PH_EXEC) && (regs.ir[7:4] == OP_MOV) && (regs.ir[3:2] != SEL_STS)
        |=> $stable(regs.sts));

    assert_branch_fall_R12: assert property (@(posedge clk) disable iff (rst)
        (regs.phase == PH_EXEC) && (regs.ir[7:6] == 2'b11) && !regs.sts[regs.ir[5:4]]
        |=> regs.pc == AW'($past(regs.pc) + AW'(2)));

endmodule

bind nib_core nib_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .regs     (cur_q)
);

// File: tb/nib_core_bench.sv
`timescale 1ns/1ps
module nib_core_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic [7:0] rdata_q = 8'h00;

    logic [7:0] ram  [256];
    logic [7:0] mram [256];

    int n_cmp = 0;
    int n_bad = 0;

    // model results
    logic [7:0] exp_a [1024];
    logic [7:0] exp_d [1024];
    int         n_exp;
    int         total_cyc;
    logic [7:0] m_pc, m_acc, m_st;

    // observed
    logic [7:0] got_a [1024];
    logic [7:0] got_d [1024];
    logic [7:0] trace [4096];
    int         n_got;

    always #10 clk = ~clk;   // 50 MHz

    nib_core u_nib_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (rdata_q)
    );

    always @(posedge clk) begin
        if (mem_we && !rst) ram[mem_addr] <= mem_wdata;
        rdata_q <= ram[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // instruction-level reference: returns {flags, result}
    function automatic logic [15:0] ref_exec(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = a;
        logic c = 0, n = 0, dz = 0, z, l, e, g;
        int wide;
        case (op)
            4'h0: begin wide = int'(a) + int'(b); r = wide[7:0]; c = wide > 255; end
            4'h1: begin r = a - b; n = b > a; end
            4'h2: begin wide = int'(a) * int'(b); r = wide[7:0]; c = wide > 255; end
            4'h3: if (b == 0) dz = 1; else r = a / b;
            4'h4: if (b == 0) dz = 1; else r = a % b;
            4'h5: begin r = a + 8'd1; c = a == 8'hFF; end
            4'h6: begin r = a - 8'd1; n = a == 8'h00; end
            4'h7: r = b;
            4'h8: r = a & b;
            4'h9: r = a | b;
            4'hA: r = a ^ b;
            default: r = a;
        endcase
        if (op == 4'hB) begin
            z = 0; l = a < b; e = a == b; g = a > b;
        end else begin
            z = (r == 0) || dz; l = r < a; e = r == a; g = r > a;
        end
        return {2'b00, n, c, g, e, l, z, r};
    endfunction

    function automatic logic [7:0] selv(input logic [1:0] s, input logic [7:0] ob);
        case (s)
            2'd0: return ob;
            2'd1: return m_acc;
            2'd2: return m_pc;
            default: return m_st;
        endcase
    endfunction

    task automatic model_run(input int steps);
        logic [7:0] ir, ob, a, b, npc;
        logic [3:0] op;
        logic [1:0] t, s;
        logic [15:0] fr;
        bit uses;
        m_pc = 0; m_acc = 0; m_st = 0; n_exp = 0; total_cyc = 0;
        for (int i = 0; i < 256; i++) mram[i] = ram[i];
        for (int k = 0; k < steps; k++) begin
            ir = mram[m_pc]; ob = mram[8'(m_pc + 8'd1)];
            op = ir[7:4]; t = ir[3:2]; s = ir[1:0];
            uses = (op >= 4'hC) || (t == 0) || (s == 0);
            total_cyc += uses ? 4 : 3;
            if (op >= 4'hC) begin
                m_pc = m_st[op[1:0]] ? ob : 8'(m_pc + 8'd2);
            end else begin
                a = selv(t, ob); b = selv(s, ob);
                fr = ref_exec(op, a, b);
                npc = uses ? 8'(m_pc + 8'd2) : 8'(m_pc + 8'd1);
                if (op != 4'h7) m_st = fr[15:8];
                if (op != 4'hB) begin
                    case (t)
                        2'd0: begin
                            mram[8'(m_pc + 8'd1)] = fr[7:0];
                            exp_a[n_exp] = 8'(m_pc + 8'd1);
                            exp_d[n_exp] = fr[7:0];
                            n_exp++;
                        end
                        2'd1: m_acc = fr[7:0];
                        2'd2: npc = fr[7:0];
                        default: m_st = fr[7:0];
                    endcase
                end
                m_pc = npc;
            end
        end
    endtask

    task automatic clear_ram();
        for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    endtask

    task automatic run_prog(input string tag, input int steps);
        model_run(steps);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_got = 0;
        for (int c = 0; c < total_cyc; c++) begin
            trace[c] = mem_addr;
            if (mem_we) begin
                got_a[n_got] = mem_addr;
                got_d[n_got] = mem_wdata;
                n_got++;
            end
            @(posedge clk);
            @(negedge clk);
        end
        rst = 1'b1;
        // R5: exactly the predicted stores, in order
        chk(n_got == n_exp, {tag, " R5 write count"}, 16'(n_got), 16'(n_exp));
        for (int i = 0; i < n_got && i < n_exp; i++)
            chk(got_a[i] == exp_a[i] && got_d[i] == exp_d[i], {tag, " R2 store stream"},
                {got_a[i], got_d[i]}, {exp_a[i], exp_d[i]});
    endtask

    task automatic hand_write(input int idx, input logic [7:0] a, input logic [7:0] d, input string tag);
        chk(n_got > idx && got_a[idx] == a && got_d[idx] == d, tag,
            {got_a[idx], got_d[idx]}, {a, d});
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin got_a[i] = 0; got_d[i] = 0; end
        clear_ram();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: while held in reset the core fetches address 0 and never writes
        chk(mem_addr == 8'h00 && mem_we == 1'b0, "R1 reset port state", {mem_addr, 7'd0, mem_we}, 16'h0000);

        // R1/R7: store accumulator and status after reset
        clear_ram();
        ram[0] = 8'h71; ram[1] = 8'hAA; ram[2] = 8'h73; ram[3] = 8'hBB;
        run_prog("D1", 2);
        hand_write(0, 8'h01, 8'h00, "R1 acc zero after reset");
        hand_write(1, 8'h03, 8'h00, "R7 status zero after move");
        chk(trace[0] == 8'h00, "R1 first fetch address", {8'h0, trace[0]}, 16'h0000);
        chk(trace[1] == 8'h01 && trace[4] == 8'h02, "R3 decode address and 4-cycle step",
            {trace[1], trace[4]}, 16'h0102);

        // R6: jump then store
        clear_ram();
        ram[0] = 8'h78; ram[1] = 8'h10; ram[8'h10] = 8'h71;
        run_prog("D2", 2);
        chk(trace[4] == 8'h10, "R6 jump target fetch", {8'h0, trace[4]}, 16'h0010);
        hand_write(0, 8'h11, 8'h00, "R6 store after jump");

        // R8: add with carry, then read flags and result
        clear_ram();
        ram[0] = 8'h74; ram[1] = 8'hF0; ram[2] = 8'h04; ram[3] = 8'h20;
        ram[4] = 8'h73; ram[6] = 8'h71;
        run_prog("D3", 4);
        hand_write(0, 8'h05, 8'h12, "R8 add carry flags");
        hand_write(1, 8'h07, 8'h10, "R8 add result");

        // R9: divide by zero
        clear_ram();
        ram[0] = 8'h74; ram[1] = 8'h09; ram[2] = 8'h34; ram[3] = 8'h00;
        ram[4] = 8'h73; ram[6] = 8'h71;
        run_prog("D4", 4);
        hand_write(0, 8'h05, 8'h05, "R9 divide-by-zero flags");
        hand_write(1, 8'h07, 8'h09, "R9 target kept");

        // R12: compare, untaken zero branch, taken less branch
        clear_ram();
        ram[0] = 8'h74; ram[1] = 8'h05; ram[2] = 8'hB4; ram[3] = 8'h07;
        ram[4] = 8'hC0; ram[5] = 8'h40; ram[6] = 8'hD0; ram[7] = 8'h20;
        ram[8'h20] = 8'h71;
        run_prog("D5", 5);
        hand_write(0, 8'h21, 8'h05, "R12 branch fall then taken");
        chk(trace[16] == 8'h20, "R12 taken branch fetch", {8'h0, trace[16]}, 16'h0020);

        // R11: status as target overrides flags
        clear_ram();
        ram[0] = 8'h74; ram[1] = 8'h00; ram[2] = 8'h0C; ram[3] = 8'h03; ram[4] = 8'h73;
        run_prog("D6", 3);
        hand_write(0, 8'h05, 8'h03, "R11 status written by result");

        // R13: PC as source
        clear_ram();
        ram[0] = 8'h78; ram[1] = 8'h30; ram[8'h30] = 8'h76; ram[8'h31] = 8'h71;
        run_prog("D7", 3);
        hand_write(0, 8'h32, 8'h30, "R13 pc reads instruction address");

        // R4: operand byte at 0xFF, PC wraps to 0
        clear_ram();
        ram[0] = 8'h78; ram[1] = 8'hFE; ram[8'hFE] = 8'h71;
        run_prog("D8", 3);
        hand_write(0, 8'hFF, 8'h00, "R4 store at top address");
        chk(trace[8] == 8'h00, "R4 pc wraps to zero", {8'h0, trace[8]}, 16'h0000);

        // R10: logic op flags
        clear_ram();
        ram[0] = 8'h74; ram[1] = 8'h0F; ram[2] = 8'h84; ram[3] = 8'h3C;
        ram[4] = 8'h73; ram[6] = 8'h71;
        run_prog("D9", 4);
        hand_write(0, 8'h05, 8'h02, "R10 and flags");
        hand_write(1, 8'h07, 8'h0C, "R10 and result");

        // random images
        void'($urandom(32'd4242));
        for (int p = 0; p < 10; p++) begin
            for (int i = 0; i < 256; i++) ram[i] = 8'($urandom());
            run_prog("RND R8 R10", 150);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired R3");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule